// File: doc/BRIEF.md
# LPC I/O Target Decoder

This block is the peripheral end of LPC I/O read and I/O write cycles. A host drives a 4-bit multiplexed nibble bus and marks each cycle start with an active-low frame strobe. The block follows the cycle one nibble per clock. It reads the start and cycle-type nibbles and collects a 16-bit I/O address, most significant nibble first. It claims the cycle only if that address equals one entry of a small table of register addresses, set by a parameter.

On a claimed cycle the block drives a sync nibble. For a read it then returns one byte taken from its register-side read-data input, low nibble first. For a write it gathers the byte the host sent. In both cases it closes the cycle by driving 1111 for one clock, and the register-side effect happens in that same clock: a one-clock write strobe carrying the byte and the table index, or a one-clock read acknowledge that lets the register owner update its flags. Because the commit waits for that clock, a cycle aborted with the frame strobe at any earlier point leaves every register untouched.

Clock numbering below counts the start nibble as clock 1. The FSM states are:

| State | Meaning |
|---|---|
| ST_IDLE | wait for a start |
| ST_CTYPE | cycle-type nibble |
| ST_ADDR0 to ST_ADDR3 | address nibbles |
| ST_WDAT_LO, ST_WDAT_HI | write data nibbles |
| ST_TAR_REC, ST_TAR_Z | host turnaround |
| ST_SYNC | target sync |
| ST_RDAT_LO, ST_RDAT_HI | read data nibbles |
| ST_DONE_REC | final 1111 and commit |

The transitions are:
- A low frame with 0000 enters ST_CTYPE from any state. A low frame with any other nibble enters ST_IDLE.
- ST_CTYPE with 0000 or 0010 enters ST_ADDR0. Any other type nibble returns to ST_IDLE.
- ST_ADDR3 on a miss returns to ST_IDLE. On a hit it enters ST_WDAT_LO for a write or ST_TAR_REC for a read.
- ST_SYNC enters ST_DONE_REC for a write or ST_RDAT_LO for a read.
- ST_DONE_REC returns to ST_IDLE.
- Every other state steps to the next state in the order of the table above.

Top module: `lpc_io_target`

## Requirements
- R1: During and right after reset, lad_oe, busy, wr_stb and rd_ack are all 0.
- R2: Read cycle (start 0000 with frame_n low at clock 1, type 0000 at clock 2, address nibbles bits 15:12..3:0 at clocks 3-6, host turnaround at clocks 7-8): the target drives 0000 at clock 9, the read byte's bits 3:0 at clock 10, bits 7:4 at clock 11, 1111 at clock 12, and releases the bus at clock 13.
- R3: The byte returned is the rd_data value present at the end of clock 9 (sync). Values of rd_data before or after that edge have no effect on the returned nibbles.
- R4: Write cycle (type 0010): data bits 3:0 arrive at clock 7 and bits 7:4 at clock 8, the host turns the bus around at clocks 9-10, the target drives 0000 at clock 11 and 1111 at clock 12. wr_stb is high for clock 12 only, with wr_data holding the byte.
- R5: When the assembled address equals no table entry, lad_oe, busy, wr_stb and rd_ack stay 0 for the whole cycle.
- R6: A type nibble other than 0000 or 0010 is ignored: lad_oe, busy, wr_stb and rd_ack stay 0 until the next start.
- R7: frame_n low at any clock from 2 to 11 aborts the cycle. No strobe is given, and busy and lad_oe are 0 from the next clock on. If the nibble in that clock is 0000, a new cycle begins there.
- R8: busy is 1 for clocks 7 to 12 of a claimed cycle, and 0 otherwise.
- R9: rd_ack is high for clock 12 only of a claimed read. wr_stb and rd_ack are never high together.
- R10: With a strobe, reg_idx gives the matched entry's position in REG_ADDRS, where entry k is bits 16k+15:16k. If several entries match, the lowest index wins.
- R11: lad_oe is 1 only in the target-driven clocks (sync, read data, final 1111). It is never 1 in host clocks or in the second turnaround clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle frame strobe |
| lad_in | input | 4 | Nibble bus as seen at the pins |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Enable for lad_out onto the bus |
| busy | output | 1 | A matched cycle is in progress |
| reg_idx | output | IDX_W | Index of the matched table entry |
| wr_stb | output | 1 | One-clock write commit |
| wr_data | output | 8 | Byte written by the host |
| rd_data | input | 8 | Byte to return on a read |
| rd_ack | output | 1 | One-clock read commit |

## Verification
The bench tries every abort clock from 2 to 12 on both reads and writes. A design that commits too early would give a strobe on a cycle aborted at clock 11, and one that commits late would miss the clock 12 strobe. Single-bit flips of a table address and all sixteen type nibbles check that the target stays off the bus when it should. A design that decodes only part of the address or type would drive LAD against the host. The rd_data input holds the wanted byte only during the sync clock, so latching one clock early or late returns the wrong nibbles. Restarting from inside a claimed cycle shows whether the previous transfer's state leaks into the new one.

// File: rtl/lpc_tgt_pkg.sv
`timescale 1ns/1ps
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR0,
        ST_ADDR1,
        ST_ADDR2,
        ST_ADDR3,
        ST_WDAT_LO,
        ST_WDAT_HI,
        ST_TAR_REC,
        ST_TAR_Z,
        ST_SYNC,
        ST_RDAT_LO,
        ST_RDAT_HI,
        ST_DONE_REC
    } lpc_state_t;

    localparam logic [3:0] NIB_START   = 4'h0;
    localparam logic [3:0] NIB_IO_RD   = 4'h0;
    localparam logic [3:0] NIB_IO_WR   = 4'h2;
    localparam logic [3:0] NIB_SYNC_OK = 4'h0;
    localparam logic [3:0] NIB_REC     = 4'hF;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/lpc_addr_match.sv
`timescale 1ns/1ps
module lpc_addr_match #(
    parameter int N_REGS = 4,
    parameter int IDX_W  = 2,
    parameter logic [N_REGS*16-1:0] REG_ADDRS = '0
) (
    input  logic [15:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [N_REGS-1:0] eq;

    for (genvar g = 0; g < N_REGS; g++) begin : g_cmp
        assign eq[g] = (addr == REG_ADDRS[g*16 +: 16]);
    end

    // lowest table index wins when entries repeat
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N_REGS - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lpc_cycle_fsm.sv
`timescale 1ns/1ps
module lpc_cycle_fsm
    import lpc_tgt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] lad_in,
    input  logic       addr_hit,
    output lpc_state_t state,
    output logic       is_write
);

    lpc_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            is_write <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_CTYPE && frame_n)
                is_write <= (lad_in == NIB_IO_WR);
        end
    end

    always_comb begin
        nxt = state;
        if (!frame_n) begin
            nxt = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_CTYPE:    nxt = (lad_in == NIB_IO_RD || lad_in == NIB_IO_WR)
                                   ? ST_ADDR0 : ST_IDLE;
                ST_ADDR0:    nxt = ST_ADDR1;
                ST_ADDR1:    nxt = ST_ADDR2;
                ST_ADDR2:    nxt = ST_ADDR3;
                ST_ADDR3:    nxt = !addr_hit ? ST_IDLE
                                   : (is_write ? ST_WDAT_LO : ST_TAR_REC);
                ST_WDAT_LO:  nxt = ST_WDAT_HI;
                ST_WDAT_HI:  nxt = ST_TAR_REC;
                ST_TAR_REC:  nxt = ST_TAR_Z;
                ST_TAR_Z:    nxt = ST_SYNC;
                ST_SYNC:     nxt = is_write ? ST_DONE_REC : ST_RDAT_LO;
                ST_RDAT_LO:  nxt = ST_RDAT_HI;
                ST_RDAT_HI:  nxt = ST_DONE_REC;
                ST_DONE_REC: nxt = ST_IDLE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpc_data_path.sv
`timescale 1ns/1ps
module lpc_data_path
    import lpc_tgt_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  lpc_state_t         state,
    input  logic [3:0]         lad_in,
    input  logic [BYTE_W-1:0]  rd_data,
    input  logic [IDX_W-1:0]   match_idx,
    output logic [ADDR_W-1:0]  addr_full,
    output logic [BYTE_W-1:0]  wr_byte,
    output logic [BYTE_W-1:0]  rd_byte,
    output logic [IDX_W-1:0]   idx_q
);

    logic [ADDR_W-5:0] addr_q;

    // the last address nibble is taken straight from the bus
    assign addr_full = {addr_q, lad_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wr_byte <= '0;
            rd_byte <= '0;
            idx_q   <= '0;
        end else begin
            if (state == ST_ADDR0 || state == ST_ADDR1 || state == ST_ADDR2)
                addr_q <= {addr_q[ADDR_W-9:0], lad_in};
            if (state == ST_ADDR3)
                idx_q <= match_idx;
            if (state == ST_WDAT_LO)
                wr_byte[3:0] <= lad_in;
            if (state == ST_WDAT_HI)
                wr_byte[7:4] <= lad_in;
            if (state == ST_SYNC)
                rd_byte <= rd_data;
        end
    end

endmodule

// File: rtl/lpc_io_target.sv
`timescale 1ns/1ps
module lpc_io_target
    import lpc_tgt_pkg::*;
#(
    parameter int N_REGS = 4,
    parameter logic [N_REGS*16-1:0] REG_ADDRS =
        {16'h0CA3, 16'h0CA2, 16'h0062, 16'h0060},
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [3:0]       lad_in,
    output logic [3:0]       lad_out,
    output logic             lad_oe,
    output logic             busy,
    output logic [IDX_W-1:0] reg_idx,
    output logic             wr_stb,
    output logic [7:0]       wr_data,
    input  logic [7:0]       rd_data,
    output logic             rd_ack
);

    lpc_state_t         state;
    logic               is_write;
    logic               addr_hit;
    logic [IDX_W-1:0]   match_idx;
    logic [ADDR_W-1:0]  addr_full;
    logic [BYTE_W-1:0]  rd_byte;

    lpc_cycle_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .lad_in   (lad_in),
        .addr_hit (addr_hit),
        .state    (state),
        .is_write (is_write)
    );

    lpc_addr_match #(
        .N_REGS    (N_REGS),
        .IDX_W     (IDX_W),
        .REG_ADDRS (REG_ADDRS)
    ) u_match (
        .addr (addr_full),
        .hit  (addr_hit),
        .idx  (match_idx)
    );

    lpc_data_path #(
        .IDX_W (IDX_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .lad_in    (lad_in),
        .rd_data   (rd_data),
        .match_idx (match_idx),
        .addr_full (addr_full),
        .wr_byte   (wr_data),
        .rd_byte   (rd_byte),
        .idx_q     (reg_idx)
    );

    // outputs are decoded from the state
    always_comb begin
        lad_out = NIB_REC;
        lad_oe  = 1'b0;
        busy    = 1'b0;
        wr_stb  = 1'b0;
        rd_ack  = 1'b0;
        unique case (state)
            ST_IDLE, ST_CTYPE,
            ST_ADDR0, ST_ADDR1, ST_ADDR2, ST_ADDR3: ;
            ST_WDAT_LO, ST_WDAT_HI,
            ST_TAR_REC, ST_TAR_Z: busy = 1'b1;
            ST_SYNC: begin
                busy    = 1'b1;
                lad_oe  = 1'b1;
                lad_out = NIB_SYNC_OK;
            end
            ST_RDAT_LO: begin
                busy    = 1'b1;
                lad_oe  = 1'b1;
                lad_out = rd_byte[3:0];
            end
            ST_RDAT_HI: begin
                busy    = 1'b1;
                lad_oe  = 1'b1;
                lad_out = rd_byte[7:4];
            end
            ST_DONE_REC: begin
                busy    = 1'b1;
                lad_oe  = 1'b1;
                lad_out = NIB_REC;
                wr_stb  = is_write;
                rd_ack  = !is_write;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpc_io_target_chk.sv
`timescale 1ns/1ps
module lpc_io_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       busy,
    input logic       wr_stb,
    input logic       rd_ack
);

    assert_oe_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lad_oe |-> busy);

    assert_strobe_one_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_ack) |=> !(wr_stb || rd_ack));

    assert_strobe_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_ack));

    assert_commit_on_rec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_ack) |-> (lad_oe && lad_out == 4'hF));

    assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && busy) |=> (!lad_oe && !busy));

    assert_release_after_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_ack) |=> !lad_oe);

endmodule

bind lpc_io_target lpc_io_target_chk i_chk (.*);

// File: tb/test_lpc_io_target.sv
`timescale 1ns/1ps
module test_lpc_io_target;

    localparam logic [63:0] ADDRS = {16'h0CA3, 16'h0CA2, 16'h0062, 16'h0060};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_n = 1'b1;
    logic [3:0] lad_in = 4'hF;
    logic [7:0] rd_data = 8'h00;
    logic [3:0] lad_out;
    logic       lad_oe, busy, wr_stb, rd_ack;
    logic [1:0] reg_idx;
    logic [7:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpc_io_target #(.N_REGS(4), .REG_ADDRS(ADDRS)) i_lpc_io_target (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lad_in(lad_in),
        .lad_out(lad_out), .lad_oe(lad_oe), .busy(busy), .reg_idx(reg_idx),
        .wr_stb(wr_stb), .wr_data(wr_data), .rd_data(rd_data), .rd_ack(rd_ack)
    );

    function automatic logic [15:0] tbl(input int i);
        return ADDRS[i*16 +: 16];
    endfunction

    // R10: lowest matching index wins
    function automatic bit lookup(input logic [15:0] a, output int idx);
        bit h = 1'b0;
        idx = 0;
        for (int i = 3; i >= 0; i--) begin
            if (tbl(i) == a) begin
                h = 1'b1;
                idx = i;
            end
        end
        return h;
    endfunction

    task automatic check(input string scen, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", scen, what, act, exp, $time);
        end
    endtask

    task automatic slot(input logic fr, input logic [3:0] nib, input logic [7:0] rd);
        @(negedge clk);
        frame_n = fr;
        lad_in  = nib;
        rd_data = rd;
        #1;
    endtask

    function automatic logic [3:0] host_nib(input int k, input logic [3:0] ctype,
                                            input logic [15:0] addr, input logic [7:0] wd);
        case (k)
            1: return 4'h0;
            2: return ctype;
            3: return addr[15:12];
            4: return addr[11:8];
            5: return addr[7:4];
            6: return addr[3:0];
            7: return (ctype == 4'h2) ? wd[3:0] : 4'hF;
            8: return (ctype == 4'h2) ? wd[7:4] : 4'hF;
            default: return 4'hF;
        endcase
    endfunction

    task automatic partial(input logic [3:0] ctype, input logic [15:0] addr,
                           input logic [7:0] wd, input int n);
        for (int k = 1; k <= n; k++)
            slot(k != 1, host_nib(k, ctype, addr, wd), 8'h00);
    endtask

    task automatic run_cycle(input logic [3:0] ctype, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rdv,
                             input int abort_at, input bit skip_first, input string scen);
        int  idx;
        bit  hit, act_rd, act_wr;
        hit    = lookup(addr, idx);
        act_rd = hit && (ctype == 4'h0);
        act_wr = hit && (ctype == 4'h2);
        for (int k = 1; k <= 15; k++) begin
            logic       fr;
            logic [3:0] nib;
            logic [7:0] rdi;
            logic [3:0] e_out;
            bit live, e_busy, e_oe, e_wr, e_rd;
            string otag;
            fr  = (k != 1);
            nib = host_nib(k, ctype, addr, wd);
            if (k == abort_at) begin
                fr  = 1'b0;
                nib = 4'hF;
            end
            // R3: only the sync-clock value may be returned
            rdi = (k < 9) ? ~rdv : ((k == 9) ? rdv : (rdv ^ 8'hA5));
            slot(fr, nib, rdi);
            live   = (abort_at == 0) || (k <= abort_at);
            e_busy = live && (act_rd || act_wr) && k >= 7 && k <= 12;
            e_oe   = live && ((act_rd && k >= 9 && k <= 12) || (act_wr && k >= 11 && k <= 12));
            e_wr   = live && act_wr && k == 12;
            e_rd   = live && act_rd && k == 12;
            e_out  = 4'hF;
            if (act_rd) begin
                if (k == 9)  e_out = 4'h0;
                if (k == 10) e_out = rdv[3:0];
                if (k == 11) e_out = rdv[7:4];
            end else if (k == 11) begin
                e_out = 4'h0;
            end
            otag = act_rd ? ((k == 10 || k == 11) ? "R3 read nibble" : "R2 read drive")
                          : "R4 write drive";
            if (!(skip_first && k == 1)) begin
                check(scen, $sformatf("R8 busy k=%0d", k), busy, e_busy);
                check(scen, $sformatf("R11 lad_oe k=%0d", k), lad_oe, e_oe);
                if (e_oe) check(scen, $sformatf("%s k=%0d", otag, k), lad_out, e_out);
                check(scen, $sformatf("R4 wr_stb k=%0d", k), wr_stb, e_wr);
                check(scen, $sformatf("R9 rd_ack k=%0d", k), rd_ack, e_rd);
                if (e_wr || e_rd) check(scen, "R10 reg_idx", reg_idx, idx);
                if (e_wr) check(scen, "R4 wr_data", wr_data, wd);
            end
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "lad_oe in reset", lad_oe, 0);
        check("R1", "busy in reset", busy, 0);
        check("R1", "wr_stb in reset", wr_stb, 0);
        check("R1", "rd_ack in reset", rd_ack, 0);
        rst_n = 1'b1;
        slot(1'b1, 4'hF, 8'h00);
        check("R1", "quiet after reset", {lad_oe, busy, wr_stb, rd_ack}, 0);
        slot(1'b1, 4'hF, 8'h00);

        // main sweep: every entry, reads and writes, several bytes
        for (int r = 0; r < 4; r++) begin
            for (int d = 0; d < 4; d++) begin
                logic [7:0] v;
                v = (d == 0) ? 8'h00 : (d == 1) ? 8'hFF : (d == 2) ? 8'hA5 : 8'h3C;
                v = v ^ 8'(r * 17);
                run_cycle(4'h2, tbl(r), v, 8'h00, 0, 1'b0, "R4 write");
                run_cycle(4'h0, tbl(r), 8'h00, v, 0, 1'b0, "R2 read");
            end
        end

        // R5: single-bit address flips
        for (int b = 0; b < 16; b++) begin
            run_cycle(4'h0, tbl(0) ^ 16'(1 << b), 8'h00, 8'h5A, 0, 1'b0, "R5 flip read");
            run_cycle(4'h2, tbl(3) ^ 16'(1 << b), 8'hC3, 8'h00, 0, 1'b0, "R5 flip write");
        end

        // R6: every type nibble on a matching address
        for (int t = 0; t < 16; t++)
            run_cycle(4'(t), tbl(2), 8'h96, 8'h69, 0, 1'b0, "R6 type");

        // R7: abort at each clock, both directions
        for (int a = 2; a <= 12; a++) begin
            run_cycle(4'h0, tbl(1), 8'h00, 8'h7E, a, 1'b0, "R7 abort read");
            run_cycle(4'h2, tbl(3), 8'hE1, 8'h00, a, 1'b0, "R7 abort write");
        end

        // R7: restart from inside a claimed cycle
        partial(4'h2, tbl(0), 8'h44, 9);
        run_cycle(4'h0, tbl(2), 8'h00, 8'hB7, 0, 1'b1, "R7 restart read");
        partial(4'h0, tbl(1), 8'h00, 10);
        run_cycle(4'h2, tbl(3), 8'h1D, 8'h00, 0, 1'b1, "R7 restart write");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule